// File: doc/BRIEF.md
# Memory-Side Atomic Read-Modify-Write Unit

This unit sits next to a system memory and carries out single-word atomic operations for accelerator clients. A client presents an opcode, a word address, an operand and a compare value together in one cycle. The unit reads the addressed 32-bit word through a synchronous single-port memory interface with one cycle of read latency. It computes the updated word, writes it back and returns the word's value from before the update. Conditional operations return that value too.

Only one operation is in progress at a time. The unit never combines or merges requests. While it works through the read, modify and write steps it holds its ready output low, so a client that keeps its valid high simply waits. The opcode set covers swap, wrapping add and subtract, the bitwise operations, signed and unsigned minimum and maximum, clamping increment and decrement, test-and-OR and compare-and-swap.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, reqReady is 1, rspValid is 0 and memEn is 0.
- R2: A request is accepted at a rising edge where reqValid and reqReady are both 1. reqReady stays 0 from that edge until the edge that ends the response cycle. Request inputs presented while reqReady is 0 have no effect on memory or on the response.
- R3: The cycle after acceptance issues a read (memEn=1, memWe=0) to the accepted address. The third cycle after acceptance carries rspValid=1 for exactly one cycle, and any write-back happens in that same cycle at the same address.
- R4: rspData, when rspValid is 1, equals the memory word as it was before this operation, for every opcode.
- R5: Opcode 1 writes old+operand and opcode 2 writes old-operand, both modulo 2^32, with no overflow indication.
- R6: Opcode 0 writes the operand. Opcode 3 writes old AND operand. Opcodes 4 and 13 (test-and-OR) write old OR operand. Opcode 5 writes old XOR operand.
- R7: Opcode 6 writes the two's-complement minimum of old and operand. Opcode 7 writes the two's-complement maximum.
- R8: Opcode 8 writes the unsigned minimum of old and operand. Opcode 9 writes the unsigned maximum.
- R9: Opcode 10 (clamping increment) writes 0 when old >= operand (unsigned) and writes old+1 otherwise.
- R10: Opcode 11 (clamping decrement) writes the operand when old is 0 or old > operand (unsigned) and writes old-1 otherwise.
- R11: Opcode 12 (compare-and-swap) writes the operand only when old equals reqCompare. Otherwise it issues no write cycle.
- R12: Opcodes 14 and 15 issue no write and return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle and able to accept |
| reqOp | input | 4 | Operation code |
| reqAddr | input | AW | Word address |
| reqOperand | input | DW | Operand or swap value |
| reqCompare | input | DW | Compare value for compare-and-swap |
| rspValid | output | 1 | One-cycle response pulse |
| rspData | output | DW | Pre-update memory word |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable (with memEn) |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data, valid the cycle after a read |

## Verification
The assertions assume that the memory returns the addressed word exactly one cycle after a read. They also assume that nothing but this unit writes the memory while an operation is in progress. The bench models a memory with that latency, and that memory has no other writer. The bench drives inputs only on falling edges, so each request field is stable at the accepting edge. During one operation it holds reqValid high with unrelated contents to show they are not taken.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_SWAP = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd2;
  localparam logic [OP_W-1:0] OP_AND  = 4'd3;
  localparam logic [OP_W-1:0] OP_OR   = 4'd4;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd5;
  localparam logic [OP_W-1:0] OP_SMIN = 4'd6;
  localparam logic [OP_W-1:0] OP_SMAX = 4'd7;
  localparam logic [OP_W-1:0] OP_UMIN = 4'd8;
  localparam logic [OP_W-1:0] OP_UMAX = 4'd9;
  localparam logic [OP_W-1:0] OP_CINC = 4'd10;
  localparam logic [OP_W-1:0] OP_CDEC = 4'd11;
  localparam logic [OP_W-1:0] OP_CAS  = 4'd12;
  localparam logic [OP_W-1:0] OP_TOR  = 4'd13;

  // strobes from control to datapath, one per sequence step
  typedef struct packed {
    logic captureReq;
    logic memRead;
    logic captureOld;
    logic memWrite;
  } strobe_t;
endpackage

// File: rtl/atomic_ctrl.sv
module atomic_ctrl
  import atomic_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    rspValid,
  output strobe_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_MODIFY, S_WRITE} state_t;
  state_t state;
  logic   accept;

  assign reqReady = (state == S_IDLE);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:   if (accept) state <= S_READ;
        S_READ:   state <= S_MODIFY;
        S_MODIFY: state <= S_WRITE;
        S_WRITE:  state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.captureReq = accept;
    strb.memRead    = (state == S_READ);
    strb.captureOld = (state == S_MODIFY);
    strb.memWrite   = (state == S_WRITE);
  end

  assign rspValid = (state == S_WRITE);

  // R2: a second request cannot be taken right behind the first
  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R3: a response is preceded by its acceptance three edges earlier
  a_r3_rsp_latency: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady, 3));
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/atomic_datapath.sv
module atomic_datapath
  import atomic_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [OP_W-1:0] reqOp,
  input  logic [AW-1:0]   reqAddr,
  input  logic [DW-1:0]   reqOperand,
  input  logic [DW-1:0]   reqCompare,
  input  logic [DW-1:0]   memRdata,
  output logic [AW-1:0]   addrQ,
  output logic [DW-1:0]   oldQ,
  output logic [DW-1:0]   newQ,
  output logic            weQ
);
  logic [OP_W-1:0] opQ;
  logic [DW-1:0]   opdQ, cmpQ;
  logic [DW-1:0]   newNext;
  logic            weNext;
  localparam logic [DW-1:0] ONE = DW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= '0;
      addrQ <= '0;
      opdQ  <= '0;
      cmpQ  <= '0;
      oldQ  <= '0;
      newQ  <= '0;
      weQ   <= 1'b0;
    end else begin
      if (strb.captureReq) begin
        opQ   <= reqOp;
        addrQ <= reqAddr;
        opdQ  <= reqOperand;
        cmpQ  <= reqCompare;
      end
      if (strb.captureOld) begin
        oldQ <= memRdata;
        newQ <= newNext;
        weQ  <= weNext;
      end
    end
  end

  always_comb begin
    newNext = memRdata;
    weNext  = 1'b1;
    unique case (opQ)
      OP_SWAP: newNext = opdQ;
      OP_ADD:  newNext = memRdata + opdQ;
      OP_SUB:  newNext = memRdata - opdQ;
      OP_AND:  newNext = memRdata & opdQ;
      OP_OR,
      OP_TOR:  newNext = memRdata | opdQ;
      OP_XOR:  newNext = memRdata ^ opdQ;
      OP_SMIN: newNext = ($signed(memRdata) < $signed(opdQ)) ? memRdata : opdQ;
      OP_SMAX: newNext = ($signed(memRdata) > $signed(opdQ)) ? memRdata : opdQ;
      OP_UMIN: newNext = (memRdata < opdQ) ? memRdata : opdQ;
      OP_UMAX: newNext = (memRdata > opdQ) ? memRdata : opdQ;
      OP_CINC: newNext = (memRdata >= opdQ) ? '0 : memRdata + ONE;
      OP_CDEC: newNext = ((memRdata == '0) || (memRdata > opdQ)) ? opdQ : memRdata - ONE;
      OP_CAS: begin
        newNext = opdQ;
        weNext  = (memRdata == cmpQ);
      end
      default: weNext = 1'b0;
    endcase
  end

  // R11: compare-and-swap only stores when the held word matched
  a_r11_cas_guard: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWrite && weQ && opQ == OP_CAS) |-> (oldQ == cmpQ));
  // R9: clamping increment stores either zero or the successor
  a_r9_clamp_inc: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWrite && weQ && opQ == OP_CINC) |-> (newQ == '0 || newQ == oldQ + ONE));
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [OP_W-1:0] reqOp,
  input  logic [AW-1:0]   reqAddr,
  input  logic [DW-1:0]   reqOperand,
  input  logic [DW-1:0]   reqCompare,
  output logic            rspValid,
  output logic [DW-1:0]   rspData,
  output logic            memEn,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata
);
  strobe_t        strb;
  logic [AW-1:0]  addrQ;
  logic [DW-1:0]  oldQ, newQ;
  logic           weQ;

  atomic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .rspValid(rspValid), .strb(strb)
  );

  atomic_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqOperand(reqOperand),
    .reqCompare(reqCompare), .memRdata(memRdata),
    .addrQ(addrQ), .oldQ(oldQ), .newQ(newQ), .weQ(weQ)
  );

  assign memWe    = strb.memWrite && weQ;
  assign memEn    = strb.memRead || memWe;
  assign memAddr  = addrQ;
  assign memWdata = newQ;
  assign rspData  = oldQ;

  // R3: every write is preceded two cycles earlier by a read of the word
  a_r3_read_before_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(memEn && !memWe, 2));
  a_r2_no_access_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memEn);
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [3:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqOperand = '0, reqCompare = '0;
  logic rspValid;
  logic [DW-1:0] rspData;
  logic memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] refMem [DEPTH];
  int checks = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  atomic_rmw_unit #(.AW(AW), .DW(DW)) u_atomic_rmw_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqOperand(reqOperand),
    .reqCompare(reqCompare), .rspValid(rspValid), .rspData(rspData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: returns {writeFlag, newValue}
  function automatic logic [32:0] refOp(input logic [3:0] op, input logic [31:0] o,
                                        input logic [31:0] d, input logic [31:0] c);
    int signed so, sd;
    so = o; sd = d;
    case (op)
      0:  return {1'b1, d};
      1:  return {1'b1, 32'(o + d)};
      2:  return {1'b1, 32'(o - d)};
      3:  return {1'b1, o & d};
      4, 13: return {1'b1, o | d};
      5:  return {1'b1, o ^ d};
      6:  return {1'b1, (so < sd) ? o : d};
      7:  return {1'b1, (so > sd) ? o : d};
      8:  return {1'b1, (o < d) ? o : d};
      9:  return {1'b1, (o > d) ? o : d};
      10: return {1'b1, (o >= d) ? 32'd0 : 32'(o + 1)};
      11: return {1'b1, (o == 0 || o > d) ? d : 32'(o - 1)};
      12: return {o == c, d};
      default: return {1'b0, o};
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      1, 2: return "R5";
      0, 3, 4, 5, 13: return "R6";
      6, 7: return "R7";
      8, 9: return "R8";
      10: return "R9";
      11: return "R10";
      12: return "R11";
      default: return "R12";
    endcase
  endfunction

  // one operation, checked on every cycle from acceptance to the return to idle
  task automatic doOp(input logic [3:0] op, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [31:0] c, input bit holdJunk);
    logic [31:0] old;
    logic [32:0] r;
    old = refMem[a];
    r = refOp(op, old, d, c);
    if (r[32]) refMem[a] = r[31:0];
    reqOp = op; reqAddr = a; reqOperand = d; reqCompare = c; reqValid = 1'b1;
    chk(reqReady === 1'b1, "R2 ready before accept", {31'b0, reqReady}, 1);
    @(posedge clk);
    @(negedge clk);
    if (holdJunk) begin
      reqOp = 4'd0; reqAddr = a ^ 4'h8; reqOperand = 32'hDEAD_BEEF;
    end else reqValid = 1'b0;
    chk(memEn === 1'b1 && memWe === 1'b0, "R3 read issued", {30'b0, memEn, memWe}, 32'd2);
    chk(memAddr === a, "R3 read address", 32'(memAddr), 32'(a));
    chk(reqReady === 1'b0 && rspValid === 1'b0, "R2 busy after accept",
        {30'b0, reqReady, rspValid}, 0);
    @(negedge clk);
    chk(memEn === 1'b0 && reqReady === 1'b0 && rspValid === 1'b0, "R3 modify cycle quiet",
        {29'b0, memEn, reqReady, rspValid}, 0);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid === 1'b1, "R3 response cycle", {31'b0, rspValid}, 1);
    chk(rspData === old, "R4 pre-update value", rspData, old);
    chk(memWe === r[32] && memEn === r[32], {tagOf(op), " write strobe"},
        {30'b0, memEn, memWe}, {30'b0, r[32], r[32]});
    if (r[32]) begin
      chk(memWdata === r[31:0], {tagOf(op), " written value"}, memWdata, r[31:0]);
      chk(memAddr === a, "R3 write address", 32'(memAddr), 32'(a));
    end
    @(negedge clk);
    chk(rspValid === 1'b0 && reqReady === 1'b1, "R3 single pulse, idle again",
        {30'b0, rspValid, reqReady}, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 32'(i) * 32'h1357_9BDF;
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b1 && rspValid === 1'b0 && memEn === 1'b0, "R1 during reset",
        {29'b0, reqReady, rspValid, memEn}, 32'd4);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1 && rspValid === 1'b0 && memEn === 1'b0, "R1 after reset",
        {29'b0, reqReady, rspValid, memEn}, 32'd4);

    doOp(0, 1, 32'hFFFF_FFFF, 0, 0);     // R6 swap
    doOp(1, 1, 32'd1, 0, 0);             // R5 add wraps to 0
    doOp(2, 1, 32'd1, 0, 0);             // R5 subtract wraps to all ones
    doOp(3, 2, 32'h0F0F_00FF, 0, 0);     // R6
    doOp(4, 2, 32'h8000_0000, 0, 0);     // R6
    doOp(13, 3, 32'h0000_0011, 0, 0);    // R6 test-and-OR
    doOp(5, 3, 32'hFFFF_0000, 0, 0);     // R6
    doOp(0, 4, 32'h8000_0001, 0, 0);
    doOp(6, 4, 32'd5, 0, 0);             // R7 negative stays
    doOp(7, 4, 32'd5, 0, 0);             // R7 positive wins
    doOp(8, 4, 32'hFFFF_FFF0, 0, 0);     // R8
    doOp(9, 4, 32'hFFFF_FFF0, 0, 0);     // R8
    doOp(0, 5, 32'd7, 0, 0);
    doOp(10, 5, 32'd8, 0, 0);            // R9 7 -> 8
    doOp(10, 5, 32'd8, 0, 0);            // R9 8 >= 8 -> 0
    doOp(11, 5, 32'd3, 0, 0);            // R10 old 0 -> operand
    doOp(11, 5, 32'd3, 0, 0);            // R10 3 -> 2
    doOp(11, 5, 32'd1, 0, 0);            // R10 2 > 1 -> 1
    doOp(12, 6, 32'h1234_5678, refMem[6], 0);   // R11 hit
    doOp(12, 6, 32'hAAAA_AAAA, 32'h0, 0);       // R11 miss, no write
    doOp(14, 7, 32'h5555_5555, 0, 0);    // R12
    doOp(15, 7, 32'h5555_5555, 0, 1);    // R12 and R2 junk held while busy
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      doOp(lfsr[3:0], lfsr[7:4], {lfsr[15:0], lfsr[31:16]},
           lfsr[8] ? refMem[lfsr[7:4]] : lfsr, lfsr[9]);
    end
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] === refMem[i], "R2 final memory image", mem[i], refMem[i]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule